// File: doc/BRIEF.md
# Status Flags and Condition Evaluator

This block keeps the four processor status flags (zero, negative, carry, overflow) that describe the last flag-writing result. It also decides whether a conditional instruction may execute. When the write enable is high, the execution stage supplies the ALU result, the carry and overflow outputs and an operation class. The class selects which flags take new values on the next clock edge. Compare, bitwise test, plain logic and the three carry-control operations each follow their own update rule.

An instruction under decode supplies a 4-bit condition code, and the block answers with a combinational condition-true signal. That signal comes from the flags as they stand now, not from a write that is still pending. The condition can test a single flag, an unsigned relation or a signed relation that follows a compare. It can also be "always", which unconditional instructions use. An issue-enable output combines the condition with an instruction-valid input, so a conditional instruction whose condition fails is turned into a no-op.

Top module: `flag_cond_unit`

## Requirements
- R1: While reset (rstN low) is asserted, the flags output is 4'b0000, with bit 3 = Z, bit 2 = N, bit 1 = C, bit 0 = V.
- R2: Class 0 (arithmetic) with wrEn high loads, at the next edge, Z = (result == 0), N = the most significant bit of result, C = carryIn and V = overflowIn.
- R3: Class 1 (logic) with wrEn high loads Z and N from result. C and V keep their values.
- R4: Class 2 (compare, a subtraction whose difference is not stored) with wrEn high loads all four flags in the same way as class 0.
- R5: Class 3 (test, a bitwise AND whose result is not stored) with wrEn high loads Z only. N, C and V keep their values.
- R6: With wrEn high, class 4 clears C, class 5 sets C and class 6 inverts C. Z, N and V keep their values for all three.
- R7: Class 7, or wrEn low with any class, leaves all four flags unchanged.
- R8: The single-flag condition codes are 1 = Z, 2 = not Z, 3 = N, 4 = not N, 5 = C, 6 = not C, 7 = V and 8 = not V. Codes 1 and 2 also serve as equal and not-equal, and codes 5 and 6 serve as unsigned higher-or-equal and lower.
- R9: Unsigned relations, where C = 1 means no borrow: code 9 (higher) is true when C = 1 and Z = 0. Code 10 (lower-or-equal) is true when C = 0 or Z = 1.
- R10: Signed relations: code 11 (greater-or-equal) is true when N = V, code 12 (less) when N != V, code 13 (greater) when Z = 0 and N = V, and code 14 (less-or-equal) when Z = 1 or N != V.
- R11: Code 0 (always) is always true. Code 15 (never) is always false.
- R12: condTrue depends only on condCode and the flags already held. A flag write in the same cycle affects condTrue only after the edge that stores it.
- R13: issueEn is high exactly when instrValid is high and condTrue is high. A valid instruction whose condition fails does not issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Flag write enable for this cycle |
| opClass | input | 3 | Operation class that selects the flag update rule |
| result | input | DATA_W | ALU result of the flag-writing operation |
| carryIn | input | 1 | ALU carry out (no-borrow for subtraction) |
| overflowIn | input | 1 | ALU signed overflow |
| condCode | input | 4 | Condition code of the instruction under decode |
| instrValid | input | 1 | An instruction requests issue this cycle |
| condTrue | output | 1 | Condition holds for the current flags |
| issueEn | output | 1 | Instruction may execute (valid and condition true) |
| flags | output | 4 | Current flags {Z, N, C, V} |

## Verification
A flag write and a condition evaluation can fall in the same cycle. An instruction that writes flags shares the cycle with a conditional instruction that reads them. The bench provokes this by driving wrEn together with a condition code whose answer the pending write would flip, for example an arithmetic zero result while the code tests Z. It judges the result by comparing condTrue against the reference model's flags from before the edge, and then the flags output against the model's flags after the edge. Random runs keep both functions active in most cycles, so every class is crossed with every condition code.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;

  typedef enum logic [2:0] {
    OP_ARITH = 3'd0,
    OP_LOGIC = 3'd1,
    OP_CMP   = 3'd2,
    OP_TEST  = 3'd3,
    OP_CLC   = 3'd4,
    OP_STC   = 3'd5,
    OP_CMC   = 3'd6,
    OP_NONE  = 3'd7
  } opClass_e;

  typedef enum logic [1:0] {
    CSRC_ALU  = 2'd0,
    CSRC_ZERO = 2'd1,
    CSRC_ONE  = 2'd2,
    CSRC_FLIP = 2'd3
  } carrySrc_e;

  typedef struct packed {
    logic      ldZ;
    logic      ldN;
    logic      ldC;
    logic      ldV;
    carrySrc_e cSrc;
  } flagStrobe_t;

  localparam int CC_W     = 4;
  localparam int CC_COUNT = 1 << CC_W;

  localparam logic [CC_W-1:0] CC_ALWAYS = 4'd0;
  localparam logic [CC_W-1:0] CC_Z      = 4'd1;
  localparam logic [CC_W-1:0] CC_NZ     = 4'd2;
  localparam logic [CC_W-1:0] CC_N      = 4'd3;
  localparam logic [CC_W-1:0] CC_NN     = 4'd4;
  localparam logic [CC_W-1:0] CC_C      = 4'd5;
  localparam logic [CC_W-1:0] CC_NC     = 4'd6;
  localparam logic [CC_W-1:0] CC_V      = 4'd7;
  localparam logic [CC_W-1:0] CC_NV     = 4'd8;
  localparam logic [CC_W-1:0] CC_UHI    = 4'd9;
  localparam logic [CC_W-1:0] CC_ULE    = 4'd10;
  localparam logic [CC_W-1:0] CC_SGE    = 4'd11;
  localparam logic [CC_W-1:0] CC_SLT    = 4'd12;
  localparam logic [CC_W-1:0] CC_SGT    = 4'd13;
  localparam logic [CC_W-1:0] CC_SLE    = 4'd14;
  localparam logic [CC_W-1:0] CC_NEVER  = 4'd15;

endpackage

// File: rtl/flag_cond_ctrl.sv
module flag_cond_ctrl
  import flag_cond_pkg::*;
(
  input  logic        wrEn,
  input  logic [2:0]  opClass,
  output flagStrobe_t strobe
);

  opClass_e opSel;
  assign opSel = opClass_e'(opClass);

  always_comb begin
    strobe = '{ldZ: 1'b0, ldN: 1'b0, ldC: 1'b0, ldV: 1'b0, cSrc: CSRC_ALU};
    if (wrEn) begin
      unique case (opSel)
        OP_ARITH, OP_CMP: begin
          strobe.ldZ = 1'b1;
          strobe.ldN = 1'b1;
          strobe.ldC = 1'b1;
          strobe.ldV = 1'b1;
        end
        OP_LOGIC: begin
          strobe.ldZ = 1'b1;
          strobe.ldN = 1'b1;
        end
        OP_TEST: strobe.ldZ = 1'b1;
        OP_CLC: begin
          strobe.ldC  = 1'b1;
          strobe.cSrc = CSRC_ZERO;
        end
        OP_STC: begin
          strobe.ldC  = 1'b1;
          strobe.cSrc = CSRC_ONE;
        end
        OP_CMC: begin
          strobe.ldC  = 1'b1;
          strobe.cSrc = CSRC_FLIP;
        end
        OP_NONE: ;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flag_cond_dp.sv
module flag_cond_dp
  import flag_cond_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [DATA_W-1:0] result,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic [CC_W-1:0]   condCode,
  output logic [3:0]        flags,
  output logic              condTrue
);

  localparam int MSB = DATA_W - 1;

  logic flagZ, flagN, flagC, flagV;
  logic nextC;
  logic [CC_COUNT-1:0] condVec;

  always_comb begin
    unique case (strobe.cSrc)
      CSRC_ZERO: nextC = 1'b0;
      CSRC_ONE:  nextC = 1'b1;
      CSRC_FLIP: nextC = ~flagC;
      default:   nextC = carryIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagC <= 1'b0;
      flagV <= 1'b0;
    end else begin
      if (strobe.ldZ) flagZ <= (result == '0);
      if (strobe.ldN) flagN <= result[MSB];
      if (strobe.ldC) flagC <= nextC;
      if (strobe.ldV) flagV <= overflowIn;
    end
  end

  assign flags = {flagZ, flagN, flagC, flagV};

  always_comb begin
    condVec           = '0;
    condVec[CC_ALWAYS] = 1'b1;
    condVec[CC_Z]     = flagZ;
    condVec[CC_NZ]    = ~flagZ;
    condVec[CC_N]     = flagN;
    condVec[CC_NN]    = ~flagN;
    condVec[CC_C]     = flagC;
    condVec[CC_NC]    = ~flagC;
    condVec[CC_V]     = flagV;
    condVec[CC_NV]    = ~flagV;
    condVec[CC_UHI]   = flagC & ~flagZ;
    condVec[CC_ULE]   = ~flagC | flagZ;
    condVec[CC_SGE]   = ~(flagN ^ flagV);
    condVec[CC_SLT]   = flagN ^ flagV;
    condVec[CC_SGT]   = ~flagZ & ~(flagN ^ flagV);
    condVec[CC_SLE]   = flagZ | (flagN ^ flagV);
    condVec[CC_NEVER] = 1'b0;
  end

  assign condTrue = condVec[condCode];

  // R11: the always code passes whatever the flags hold
  a_r11_always_true: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_ALWAYS) |-> condTrue);

  // R11: the never code blocks whatever the flags hold
  a_r11_never_false: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_NEVER) |-> !condTrue);

  // R10: signed greater and signed less-or-equal are complementary
  a_r10_sgt_excl: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_SGT && condTrue) |-> !condVec[CC_SLE]);

endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        opClass,
  input  logic [DATA_W-1:0] result,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic [3:0]        condCode,
  input  logic              instrValid,
  output logic              condTrue,
  output logic              issueEn,
  output logic [3:0]        flags
);

  flagStrobe_t strobe;

  flag_cond_ctrl u_ctrl (
    .wrEn    (wrEn),
    .opClass (opClass),
    .strobe  (strobe)
  );

  flag_cond_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .result     (result),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .condCode   (condCode),
    .flags      (flags),
    .condTrue   (condTrue)
  );

  assign issueEn = instrValid & condTrue;

  // R3: a logic operation leaves overflow and carry alone
  a_r3_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass == OP_LOGIC) |=> $stable(flags[1:0]));

  // R5: a test operation touches only Z
  a_r5_test_only_z: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass == OP_TEST) |=> $stable(flags[2:0]));

  // R6: set-carry ends with C high and the other flags held
  a_r6_stc_sets_c: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass == OP_STC) |=> (flags[1] && $stable(flags[3:2]) && $stable(flags[0])));

  // R6: complement-carry flips C
  a_r6_cmc_flips_c: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opClass == OP_CMC) |=> (flags[1] != $past(flags[1])));

  // R7: no write leaves every flag unchanged
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || opClass == OP_NONE) |=> $stable(flags));

  // R13: an invalid slot never issues
  a_r13_no_issue_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !issueEn);

endmodule

// File: tb/flag_cond_unit_bench.sv
`timescale 1ns/1ps
module flag_cond_unit_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   opClass = 3'd7;
  logic [W-1:0] result = '0;
  logic         carryIn = 1'b0;
  logic         overflowIn = 1'b0;
  logic [3:0]   condCode = 4'd0;
  logic         instrValid = 1'b0;
  logic         condTrue, issueEn;
  logic [3:0]   flags;

  int checks = 0;
  int errors = 0;
  bit refZ = 0, refN = 0, refC = 0, refV = 0;
  string lastTag = "R1";

  always #4 clk = ~clk;

  flag_cond_unit #(.DATA_W(W)) u_flag_cond_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opClass(opClass), .result(result),
    .carryIn(carryIn), .overflowIn(overflowIn), .condCode(condCode),
    .instrValid(instrValid), .condTrue(condTrue), .issueEn(issueEn), .flags(flags)
  );

  function automatic bit expectCond(logic [3:0] cc);
    case (cc)
      4'd0:  return 1;
      4'd1:  return refZ;
      4'd2:  return !refZ;
      4'd3:  return refN;
      4'd4:  return !refN;
      4'd5:  return refC;
      4'd6:  return !refC;
      4'd7:  return refV;
      4'd8:  return !refV;
      4'd9:  return refC && !refZ;
      4'd10: return !refC || refZ;
      4'd11: return refN == refV;
      4'd12: return refN != refV;
      4'd13: return !refZ && (refN == refV);
      4'd14: return refZ || (refN != refV);
      default: return 0;
    endcase
  endfunction

  function automatic string condTag(logic [3:0] cc);
    if (cc == 0 || cc == 15) return "R11";
    if (cc <= 8) return "R8";
    if (cc <= 10) return "R9";
    return "R10";
  endfunction

  function automatic string opTag(bit wr, logic [2:0] op);
    if (!wr) return "R7";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5, 3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit wr, logic [2:0] op, logic [W-1:0] res, bit cy, bit ov,
                      logic [3:0] cc, bit iv);
    bit expC;
    @(negedge clk);
    wrEn = wr; opClass = op; result = res; carryIn = cy; overflowIn = ov;
    condCode = cc; instrValid = iv;
    #1;
    chk(lastTag, flags, {refZ, refN, refC, refV});
    // R12: condition is judged on flags held before this cycle's write
    expC = expectCond(cc);
    chk(condTag(cc), {3'b0, condTrue}, {3'b0, expC});
    chk("R13", {3'b0, issueEn}, {3'b0, iv && expC});
    @(posedge clk);
    if (wr) begin
      case (op)
        3'd0, 3'd2: begin refZ = (res == 0); refN = res[W-1]; refC = cy; refV = ov; end
        3'd1: begin refZ = (res == 0); refN = res[W-1]; end
        3'd3: refZ = (res == 0);
        3'd4: refC = 0;
        3'd5: refC = 1;
        3'd6: refC = !refC;
        default: ;
      endcase
    end
    lastTag = opTag(wr, op);
  endtask

  task automatic sweepCodes();
    for (int k = 0; k < 16; k++) step(0, 3'd0, 16'h1234, 1, 1, k[3:0], k[0]);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", flags, 4'b0000);
    chk("R11", {3'b0, condTrue}, 4'b0001);
    @(negedge clk);
    rstN = 1'b1;

    step(1, 3'd0, 16'h0000, 1, 0, 4'd1, 1);   // R12: Z still 0 in this cycle
    sweepCodes();
    step(1, 3'd0, 16'h8000, 0, 1, 4'd11, 1);  // R2 negative with overflow
    sweepCodes();
    step(1, 3'd1, 16'h0000, 0, 0, 4'd3, 1);   // R3 logic keeps C,V
    sweepCodes();
    step(1, 3'd2, 16'h8001, 1, 0, 4'd9, 1);   // R4 compare
    sweepCodes();
    step(1, 3'd2, 16'h0000, 1, 0, 4'd0, 1);   // R4 equal
    sweepCodes();
    step(1, 3'd3, 16'h0000, 0, 1, 4'd2, 1);   // R5 test only Z
    step(1, 3'd3, 16'h0040, 0, 1, 4'd1, 1);
    step(1, 3'd4, 16'h0000, 1, 1, 4'd5, 1);   // R6 clear carry
    step(1, 3'd5, 16'h0000, 0, 0, 4'd6, 1);   // R6 set carry
    step(1, 3'd6, 16'h0000, 1, 1, 4'd5, 1);   // R6 complement
    step(1, 3'd6, 16'h0000, 0, 0, 4'd5, 1);
    step(1, 3'd7, 16'h0000, 1, 1, 4'd15, 1);  // R7 no-op class
    step(0, 3'd0, 16'h0000, 1, 1, 4'd14, 0);  // R7 write disabled
    sweepCodes();

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] r;
      r = ($urandom % 4 == 0) ? '0 : W'($urandom);
      step($urandom % 4 != 0, 3'($urandom), r, 1'($urandom), 1'($urandom),
           4'($urandom), 1'($urandom));
    end
    step(0, 3'd7, 16'h0000, 0, 0, 4'd0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule